// File: doc/BRIEF.md
# Local-Bus to PCI I/O Read Initiator

This block sits between a simple strobe-and-ready local bus and a PCI bus, and acts as the initiator of one PCI I/O read at a time. A local master starts a read by pulling its active-low strobe low with the read/write line high and a valid address on the local address bus. The block then runs a fixed sequence:

1. An address phase.
2. A turnaround clock in which it asserts the initiator-ready signal.
3. A wait for the target to claim the cycle and complete it.
4. A one-clock ready pulse to the local side.
5. One clock in which the captured word is driven onto the local data bus.

The block never drives a real tri-state pin. Every bus it would float has a separate output-enable, so the pad ring or the bench decides what the bus looks like when it is released. If no target claims the cycle within a parameterised number of wait clocks, the block ends the cycle as a master abort and returns a word of all ones. It is meant for a single-master bridge in which bus arbitration is handled elsewhere or is not needed.

Top module: `pciRdInitiator`

## Requirements
- R1: After reset and while idle, `frameN`, `irdyN` and `locRdyN` are high, and `adOe`, `cbeOe` and `locDataOe` are low.
- R2: A transaction starts only on a clock where `locStrbN` is sampled low after having been high on the previous clock, with `locRnW` high. The address and byte enables are captured on that clock, and later changes on `locAddr` and `locByteEnN` do not affect the cycle.
- R3: On the clock after the start, `frameN` is low for exactly one clock. During that clock `adOe` is high with the captured address on `adOut`, and `cbeOe` is high with the I/O-read command 4'b0010 on `cbeOut`.
- R4: On the following clock, `frameN` is high, `adOe` is low for turnaround, `irdyN` is low, and `cbeOut` carries the captured active-low byte enables (4'b0000 selects all four bytes).
- R5: The block stays in the wait phase, with `irdyN` low, until it samples `trdyN` and `devselN` both low. On that clock it captures `adIn`, and `locRdyN` goes low on the next clock.
- R6: `locRdyN` is low for exactly one clock. During that clock `irdyN` is high and both `adOe` and `cbeOe` are low.
- R7: If `devselN` has not been sampled low during the wait phase and is still high on the fifth wait-phase sample (parameter `ABORT_CLKS`), the block ends the cycle as a master abort. The result is 32'hFFFF_FFFF, and the completion sequence of R6 and R8 follows.
- R8: On the clock after the ready pulse, `locDataOe` is high for exactly one clock with the result on `locData` and `locRdyN` high. After that the block is idle again.
- R9: Holding `locStrbN` low does not start a second transaction. A new read needs a high-to-low change of the strobe.
- R10: A strobe edge with `locRnW` low (a write) is ignored, and no PCI phase begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock (33 MHz class) |
| rstN | input | 1 | Asynchronous active-low reset |
| locStrbN | input | 1 | Local request strobe, active low |
| locRnW | input | 1 | Local direction, high = read |
| locAddr | input | 32 | Local address |
| locByteEnN | input | 4 | Local byte enables, active low |
| locData | output | 32 | Read result to the local side |
| locDataOe | output | 1 | Drive enable for `locData` |
| locRdyN | output | 1 | Local ready, active low |
| frameN | output | 1 | PCI FRAME#, active low |
| irdyN | output | 1 | PCI initiator ready, active low |
| adOut | output | 32 | Address driven on AD |
| adOe | output | 1 | Drive enable for AD |
| adIn | input | 32 | AD as seen from the bus |
| cbeOut | output | 4 | Command or byte enables on C/BE# |
| cbeOe | output | 1 | Drive enable for C/BE# |
| devselN | input | 1 | Target device select, active low |
| trdyN | input | 1 | Target ready, active low |

## Verification
The assertions check the pulse shapes on every cycle:
- FRAME# lasts one clock.
- IRDY# follows the release of FRAME#.
- AD turns around after its single driven clock.
- The local ready and the local data enable each last one clock.

Only the bench scenarios can show that the right address, command, byte enables and captured word appear, and that the wait phase lasts as long as the target model asks. They also show the master abort boundary: DEVSEL# on the last allowed sample is accepted, and one clock later it causes an abort. The same holds for the rules that a held strobe or a write request starts nothing.

// File: rtl/pciRdPkg.sv
package pciRdPkg;

  localparam logic [3:0] IO_RD_CMD = 4'b0010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WAIT,
    ST_RESP,
    ST_DRIVE
  } rdState_t;

  typedef struct packed {
    logic latchReq;
    logic capture;
    logic abortFill;
    logic driveAddr;
    logic driveBe;
    logic driveLocal;
  } rdStrobes_t;

endpackage

// File: rtl/pciRdCtrl.sv
module pciRdCtrl
  import pciRdPkg::*;
#(
  parameter int ABORT_CLKS = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       locStrbN,
  input  logic       locRnW,
  input  logic       devselN,
  input  logic       trdyN,
  output rdStrobes_t strobes,
  output logic       frameN,
  output logic       irdyN,
  output logic       locRdyN
);

  localparam int CNT_W = (ABORT_CLKS > 1) ? $clog2(ABORT_CLKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(ABORT_CLKS - 1);

  rdState_t   state, stateNext;
  logic       strbPrevN;
  logic       devselSeen;
  logic [CNT_W-1:0] waitCnt;
  logic       startReq;

  assign startReq = strbPrevN && !locStrbN && locRnW;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          strobes.latchReq = 1'b1;
          stateNext        = ST_ADDR;
        end
      end
      ST_ADDR: begin
        strobes.driveAddr = 1'b1;
        stateNext         = ST_WAIT;
      end
      ST_WAIT: begin
        strobes.driveBe = 1'b1;
        if (!trdyN && !devselN) begin
          strobes.capture = 1'b1;
          stateNext       = ST_RESP;
        end else if (devselN && !devselSeen && waitCnt == CNT_LIMIT) begin
          strobes.abortFill = 1'b1;
          stateNext         = ST_RESP;
        end
      end
      ST_RESP:  stateNext = ST_DRIVE;
      ST_DRIVE: begin
        strobes.driveLocal = 1'b1;
        stateNext          = ST_IDLE;
      end
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      strbPrevN  <= 1'b1;
      devselSeen <= 1'b0;
      waitCnt    <= '0;
    end else begin
      state     <= stateNext;
      strbPrevN <= locStrbN;
      if (state != ST_WAIT) begin
        devselSeen <= 1'b0;
        waitCnt    <= '0;
      end else begin
        if (!devselN) devselSeen <= 1'b1;
        if (waitCnt != CNT_LIMIT) waitCnt <= waitCnt + 1'b1;
      end
    end
  end

  assign frameN  = (state != ST_ADDR);
  assign irdyN   = (state != ST_WAIT);
  assign locRdyN = (state != ST_RESP);

  // R3: address phase lasts one clock
  a_r3_frame_one_clock: assert property (@(posedge clk) disable iff (!rstN)
    !frameN |=> frameN);
  // R4: initiator ready follows release of FRAME#
  a_r4_irdy_after_frame: assert property (@(posedge clk) disable iff (!rstN)
    !frameN |=> !irdyN);
  // R6: local ready is a single-clock pulse, with IRDY# released
  a_r6_rdy_single: assert property (@(posedge clk) disable iff (!rstN)
    !locRdyN |=> locRdyN);
  a_r6_irdy_released: assert property (@(posedge clk) disable iff (!rstN)
    !locRdyN |-> irdyN);

endmodule

// File: rtl/pciRdDatapath.sv
module pciRdDatapath
  import pciRdPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BE_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdStrobes_t        strobes,
  input  logic [ADDR_W-1:0] locAddr,
  input  logic [BE_W-1:0]   locByteEnN,
  input  logic [DATA_W-1:0] adIn,
  output logic [ADDR_W-1:0] adOut,
  output logic              adOe,
  output logic [BE_W-1:0]   cbeOut,
  output logic              cbeOe,
  output logic [DATA_W-1:0] locData,
  output logic              locDataOe
);

  logic [ADDR_W-1:0] addrReg;
  logic [BE_W-1:0]   beReg;
  logic [DATA_W-1:0] dataReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      beReg   <= '0;
      dataReg <= '0;
    end else begin
      if (strobes.latchReq) begin
        addrReg <= locAddr;
        beReg   <= locByteEnN;
      end
      if (strobes.capture)        dataReg <= adIn;
      else if (strobes.abortFill) dataReg <= '1;
    end
  end

  assign adOut     = addrReg;
  assign adOe      = strobes.driveAddr;
  assign cbeOut    = strobes.driveAddr ? BE_W'(IO_RD_CMD) : beReg;
  assign cbeOe     = strobes.driveAddr | strobes.driveBe;
  assign locData   = dataReg;
  assign locDataOe = strobes.driveLocal;

  // R4: AD is released for turnaround after its single driven clock
  a_r4_ad_turnaround: assert property (@(posedge clk) disable iff (!rstN)
    adOe |=> !adOe);
  // R8: local data is driven for one clock only
  a_r8_ld_one_clock: assert property (@(posedge clk) disable iff (!rstN)
    locDataOe |=> !locDataOe);

endmodule

// File: rtl/pciRdInitiator.sv
module pciRdInitiator
  import pciRdPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int BE_W       = 4,
  parameter int ABORT_CLKS = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              locStrbN,
  input  logic              locRnW,
  input  logic [ADDR_W-1:0] locAddr,
  input  logic [BE_W-1:0]   locByteEnN,
  output logic [DATA_W-1:0] locData,
  output logic              locDataOe,
  output logic              locRdyN,
  output logic              frameN,
  output logic              irdyN,
  output logic [ADDR_W-1:0] adOut,
  output logic              adOe,
  input  logic [DATA_W-1:0] adIn,
  output logic [BE_W-1:0]   cbeOut,
  output logic              cbeOe,
  input  logic              devselN,
  input  logic              trdyN
);

  rdStrobes_t strobes;

  pciRdCtrl #(.ABORT_CLKS(ABORT_CLKS)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .locStrbN (locStrbN),
    .locRnW   (locRnW),
    .devselN  (devselN),
    .trdyN    (trdyN),
    .strobes  (strobes),
    .frameN   (frameN),
    .irdyN    (irdyN),
    .locRdyN  (locRdyN)
  );

  pciRdDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .locAddr    (locAddr),
    .locByteEnN (locByteEnN),
    .adIn       (adIn),
    .adOut      (adOut),
    .adOe       (adOe),
    .cbeOut     (cbeOut),
    .cbeOe      (cbeOe),
    .locData    (locData),
    .locDataOe  (locDataOe)
  );

  // R6: buses are released while the local ready pulse is low
  a_r6_bus_released: assert property (@(posedge clk) disable iff (!rstN)
    !locRdyN |-> (!adOe && !cbeOe));
  // R8: local data follows the ready pulse
  a_r8_ld_after_rdy: assert property (@(posedge clk) disable iff (!rstN)
    !locRdyN |=> (locDataOe && locRdyN));

endmodule

// File: tb/pciRdInitiator_tb_top.sv
module pciRdInitiator_tb_top;

  localparam time CLK_PERIOD = 30ns;
  localparam int  ABORT_LIM  = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        locStrbN = 1'b1;
  logic        locRnW = 1'b1;
  logic [31:0] locAddr = '0;
  logic [3:0]  locByteEnN = '0;
  logic [31:0] locData;
  logic        locDataOe, locRdyN, frameN, irdyN, adOe, cbeOe;
  logic [31:0] adOut;
  logic [31:0] adIn = '0;
  logic [3:0]  cbeOut;
  logic        devselN = 1'b1;
  logic        trdyN = 1'b1;

  int unsigned nChecks = 0;
  int unsigned nFails  = 0;
  logic [31:0] expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pciRdInitiator #(.ABORT_CLKS(ABORT_LIM)) dut_i (
    .clk(clk), .rstN(rstN), .locStrbN(locStrbN), .locRnW(locRnW),
    .locAddr(locAddr), .locByteEnN(locByteEnN), .locData(locData),
    .locDataOe(locDataOe), .locRdyN(locRdyN), .frameN(frameN), .irdyN(irdyN),
    .adOut(adOut), .adOe(adOe), .adIn(adIn), .cbeOut(cbeOut), .cbeOe(cbeOe),
    .devselN(devselN), .trdyN(trdyN)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkIdle(input string req);
    check(req, {28'd0, frameN, irdyN, locRdyN, adOe}, {28'd0, 3'b111, 1'b0});
    check(req, {30'd0, cbeOe, locDataOe}, 32'd0);
  endtask

  // scoreboard monitor: compares every local data beat with the queue
  always @(negedge clk) begin
    if (rstN && locDataOe) begin
      nChecks++;
      if (expQ.size() == 0) begin
        nFails++;
        $display("FAIL R8: actual %h expected <no item>", locData);
      end else begin
        logic [31:0] e;
        e = expQ.pop_front();
        if (locData !== e) begin
          nFails++;
          $display("FAIL R8: actual %h expected %h", locData, e);
        end
      end
    end
  end

  task automatic doRead(input logic [31:0] addr, input logic [3:0] be,
                        input logic [31:0] data, input int devDelay,
                        input int waitCyc);
    bit abort;
    int cycles;
    abort = (devDelay >= ABORT_LIM);
    expQ.push_back(abort ? 32'hFFFF_FFFF : data);
    @(negedge clk);
    locStrbN = 1'b0; locRnW = 1'b1; locAddr = addr; locByteEnN = be;
    adIn = data;
    @(negedge clk);
    // R3: address phase
    check("R3 frame", {31'd0, frameN}, 32'd0);
    check("R3 ad", adOe ? adOut : 32'hDEAD_BEEF, addr);
    check("R3 cmd", {27'd0, cbeOe, cbeOut}, {27'd0, 1'b1, 4'b0010});
    check("R3 irdy", {31'd0, irdyN}, 32'd1);
    locAddr = ~addr; locByteEnN = ~be;   // R2: later changes ignored
    @(negedge clk);
    // R4: turnaround
    check("R4 frame/adOe/irdy", {29'd0, frameN, adOe, irdyN}, {29'd0, 3'b100});
    check("R4 R2 be", {27'd0, cbeOe, cbeOut}, {27'd0, 1'b1, be});
    cycles = 0;
    for (int i = 0; i < 40; i++) begin
      devselN = !(i >= devDelay);
      trdyN   = !(i >= devDelay + waitCyc);
      @(negedge clk);
      if (!locRdyN) begin cycles = i + 1; break; end
      check("R5 irdy held", {31'd0, irdyN}, 32'd0);
    end
    check("R5 R7 wait length", cycles, abort ? ABORT_LIM : devDelay + waitCyc + 1);
    // R6: completion clock
    check("R6", {28'd0, irdyN, adOe, cbeOe, locDataOe}, {28'd0, 4'b1000});
    devselN = 1'b1; trdyN = 1'b1; locStrbN = 1'b1;
    @(negedge clk);
    check("R8 drive", {30'd0, locDataOe, locRdyN}, 32'd3);
    @(negedge clk);
    checkIdle("R8 R1 back to idle");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkIdle("R1 reset");
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("R1 after reset");

    doRead(32'h0000_1000, 4'b0000, 32'h1234_5678, 1, 2);
    doRead(32'hC0DE_0004, 4'b1100, 32'hA5A5_0F0F, 0, 0);
    doRead(32'h0000_00F0, 4'b0101, 32'h0BAD_F00D, 2, 7);
    doRead(32'h1111_2220, 4'b0000, 32'h7777_8888, 4, 1);   // R7 boundary: accepted
    doRead(32'h5555_0000, 4'b0000, 32'h0000_0001, 5, 0);   // R7 master abort
    doRead(32'h5555_0010, 4'b0011, 32'h0000_0002, 9, 0);   // R7 abort, no target

    // R10: write request ignored
    @(negedge clk);
    locRnW = 1'b0; locStrbN = 1'b0;
    repeat (4) begin
      @(negedge clk);
      check("R10 write ignored", {31'd0, frameN}, 32'd1);
    end
    // R9: strobe still low, switch to read: no edge, no start
    locRnW = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check("R9 held strobe", {31'd0, frameN}, 32'd1);
    end
    locStrbN = 1'b1;
    @(negedge clk);
    doRead(32'hFFFF_FFFC, 4'b1110, 32'h0000_0000, 0, 3);
    repeat (2) @(negedge clk);
    check("R8 scoreboard drained", expQ.size(), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule